// File: doc/BRIEF.md
# BCD Time-of-Day Clock Register File

This block is a calendar clock that counts seconds, minutes, hours, day of week, date, month and a two-digit year, all in packed BCD. A one-cycle pulse on `tick_1hz` advances the count once. Software reaches the clock through a byte-wide register window of eight addresses. The window sits at the top of a 2 KB address space. Writes use a single-cycle strobe, and read data is combinational.

The block keeps three copies of the time. The running counters hold the live value. A holding copy takes software writes. A readable copy is what reads return. Setting the load-enable bit in the control byte snapshots the running counters into the holding copy. Software then edits individual fields, and clearing the bit loads the whole holding copy into the counters in one cycle. Setting the freeze bit stops the readable copy from refreshing, so a multi-byte read is coherent, while the counters keep running. Three flags share bytes with the time fields: a stop flag that halts counting, and a kick-start flag and a frequency-test flag that are only stored.

Top module: `tod_clock_regs`

## Requirements
- R1: After a synchronous active-low reset, the fields read as follows: control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01 and year 0x00.
- R2: The window starts at base 0x7F8. The offsets are 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month and 7 year. Any address outside the window reads 0x00, and a write to such an address changes nothing.
- R3: The control byte has load-enable at bit 7, freeze at bit 6 and a trim-direction bit at bit 5. Writing bit 7 = 1 while it is clear copies the running counters into the holding copy. Field writes then go to the holding copy. Writing bit 7 = 0 while it is set loads the whole holding copy into the running counters.
- R4: A write to a time field while load-enable is clear has no effect.
- R5: Seconds and minutes count 00–59 in BCD, and hours count 00–23. Each wrap carries into the next field.
- R6: On each day advance the day of week steps by one, and 07 wraps to 01.
- R7: The date wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and for February 29 when the BCD year is divisible by four, otherwise 28. The month then advances.
- R8: Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R9: The stop flag is bit 7 of the seconds byte. While it is set, ticks are ignored.
- R10: While freeze is set, reads return the values captured before it was set, and ticks still reach the counters. After freeze is cleared, the readable copy refreshes on the second clock edge counted from the write edge.
- R11: The trim-direction bit is stored and read back. Control bits 4:0 read as zero.
- R12: The kick-start flag (hours bit 7) and the frequency-test flag (day-of-week bit 6) are stored and read back, and no time update changes them. Time-field bits that are not in use read as zero.
- R13: When a holding-copy load and a tick fall in the same cycle, the load wins and that tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| addr | input | 11 | Byte address |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |

## Verification
Two functions can fall in the same cycle, and both cases are provoked on purpose.

The first is a holding-copy load and a tick. The bench drives the control write that clears load-enable together with a tick pulse. It then expects the seconds byte to show exactly the value it placed in the holding copy, not that value plus one. A further tick must then advance the count normally.

The second is a freeze and a tick. The bench ticks while the readable copy is frozen. It then expects the old value on the cycle right after the unfreeze, and the advanced value one cycle later.

// File: rtl/tod_pkg.sv
// Shared types and BCD helpers for the time-of-day clock.
// Assumes the time fields always hold packed BCD.
package tod_pkg;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic       kick;
        logic [5:0] hr;
        logic       ftest;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] yr;
    } tod_time_t;

    localparam tod_time_t TOD_RESET = '{stop: 1'b0, sec: 7'h00, min: 7'h00,
                                        kick: 1'b0, hr: 6'h00, ftest: 1'b0,
                                        dow: 3'd1, date: 6'h01, mon: 5'h01,
                                        yr: 8'h00};

    // Add one to a two-digit packed BCD value (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year is divisible by four when: tens even and units 0/4/8, or tens odd and units 2/6.
    function automatic logic bcd_leap(input logic [7:0] yr);
        if (yr[4])
            return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    endfunction

    // Last valid BCD date of a BCD month.
    function automatic logic [5:0] bcd_last_day(input logic [4:0] mon, input logic [7:0] yr);
        case (mon)
            5'h02:                      return bcd_leap(yr) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/tod_count_chain.sv
// Running BCD counters of the clock.
// Advances on a tick unless the stop flag is set, with cascaded carries
// up to the year. A load replaces all fields and takes priority over a tick.
// Assumes the tick is a single-cycle pulse.
module tod_count_chain
    import tod_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  tod_time_t load_val,
    output tod_time_t run
);

    tod_time_t  nxt;
    logic       adv, c_sec, c_min, c_hr, c_date, c_mon;
    logic [7:0] s8, m8, h8, dt8, mo8;

    // Next-state value of every field, with the carry chain.
    always_comb begin
        nxt    = run;
        adv    = tick && !run.stop;
        c_sec  = adv && (run.sec == 7'h59);
        c_min  = c_sec && (run.min == 7'h59);
        c_hr   = c_min && (run.hr == 6'h23);
        c_date = c_hr && (run.date == bcd_last_day(run.mon, run.yr));
        c_mon  = c_date && (run.mon == 5'h12);
        s8     = bcd_inc({1'b0, run.sec});
        m8     = bcd_inc({1'b0, run.min});
        h8     = bcd_inc({2'b00, run.hr});
        dt8    = bcd_inc({2'b00, run.date});
        mo8    = bcd_inc({3'b000, run.mon});
        if (adv)
            nxt.sec = c_sec ? 7'h00 : s8[6:0];
        if (c_sec)
            nxt.min = c_min ? 7'h00 : m8[6:0];
        if (c_min)
            nxt.hr = c_hr ? 6'h00 : h8[5:0];
        if (c_hr) begin
            nxt.dow  = (run.dow == 3'd7) ? 3'd1 : run.dow + 3'd1;
            nxt.date = c_date ? 6'h01 : dt8[5:0];
        end
        if (c_date)
            nxt.mon = c_mon ? 5'h01 : mo8[4:0];
        if (c_mon)
            nxt.yr = (run.yr == 8'h99) ? 8'h00 : bcd_inc(run.yr);
    end

    // Counter register: reset, load from holding copy, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= TOD_RESET;
        else if (load)
            run <= load_val;
        else
            run <= nxt;
    end

endmodule

// File: rtl/tod_bus_regs.sv
// Register window of the clock.
// Decodes eight byte addresses at WIN_BASE and keeps the control bits,
// the holding copy for software loads, and the readable copy that reads
// return. Assumes a single-cycle write strobe; read data is combinational.
module tod_bus_regs
    import tod_pkg::*;
#(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] WIN_BASE = 11'h7F8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  tod_time_t         run,
    output logic [7:0]        rd_data,
    output logic              load,
    output tod_time_t         hold,
    output tod_time_t         shadow,
    output logic              ctrl_read
);

    localparam int              WIN_W  = 3;
    localparam int              PAGE_W = ADDR_W - WIN_W;
    localparam logic [PAGE_W-1:0] WIN_PAGE = WIN_BASE[ADDR_W-1:WIN_W];
    localparam logic [WIN_W-1:0] OFF_CTRL = 3'd0;
    localparam logic [WIN_W-1:0] OFF_SEC  = 3'd1;
    localparam logic [WIN_W-1:0] OFF_MIN  = 3'd2;
    localparam logic [WIN_W-1:0] OFF_HR   = 3'd3;
    localparam logic [WIN_W-1:0] OFF_DOW  = 3'd4;
    localparam logic [WIN_W-1:0] OFF_DATE = 3'd5;
    localparam logic [WIN_W-1:0] OFF_MON  = 3'd6;
    localparam logic [WIN_W-1:0] OFF_YR   = 3'd7;

    logic             hit, ctrl_we, field_we, capture;
    logic [WIN_W-1:0] off;
    logic             wr_q, rd_q, sign_q;

    // Address decode and write qualification.
    always_comb begin
        hit      = (addr[ADDR_W-1:WIN_W] == WIN_PAGE);
        off      = addr[WIN_W-1:0];
        ctrl_we  = wr_en && hit && (off == OFF_CTRL);
        field_we = wr_en && hit && (off != OFF_CTRL) && wr_q;
        capture  = ctrl_we && wr_data[7] && !wr_q;
        load     = ctrl_we && !wr_data[7] && wr_q;
    end

    assign ctrl_read = rd_q;

    // Control bits: load-enable, freeze, trim direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
            sign_q <= 1'b0;
        end else if (ctrl_we) begin
            wr_q   <= wr_data[7];
            rd_q   <= wr_data[6];
            sign_q <= wr_data[5];
        end
    end

    // Holding copy: snapshot on load-enable rise, then per-field writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= TOD_RESET;
        else if (capture)
            hold <= run;
        else if (field_we) begin
            case (off)
                OFF_SEC:  begin hold.stop <= wr_data[7]; hold.sec <= wr_data[6:0]; end
                OFF_MIN:  hold.min <= wr_data[6:0];
                OFF_HR:   begin hold.kick <= wr_data[7]; hold.hr <= wr_data[5:0]; end
                OFF_DOW:  begin hold.ftest <= wr_data[6]; hold.dow <= wr_data[2:0]; end
                OFF_DATE: hold.date <= wr_data[5:0];
                OFF_MON:  hold.mon <= wr_data[4:0];
                OFF_YR:   hold.yr <= wr_data;
                default:  ;
            endcase
        end
    end

    // Readable copy: follows the counters unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= TOD_RESET;
        else if (!rd_q)
            shadow <= run;
    end

    // Combinational read mux with zero fill of unused bits.
    always_comb begin
        rd_data = 8'h00;
        if (hit) begin
            case (off)
                OFF_CTRL: rd_data = {wr_q, rd_q, sign_q, 5'b00000};
                OFF_SEC:  rd_data = {shadow.stop, shadow.sec};
                OFF_MIN:  rd_data = {1'b0, shadow.min};
                OFF_HR:   rd_data = {shadow.kick, 1'b0, shadow.hr};
                OFF_DOW:  rd_data = {1'b0, shadow.ftest, 3'b000, shadow.dow};
                OFF_DATE: rd_data = {2'b00, shadow.date};
                OFF_MON:  rd_data = {3'b000, shadow.mon};
                OFF_YR:   rd_data = shadow.yr;
                default:  rd_data = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/tod_clock_regs.sv
// Top of the BCD time-of-day clock: a register window plus running counters.
// Assumes tick_1hz is a one-cycle pulse synchronous to clk.
module tod_clock_regs
    import tod_pkg::*;
#(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] WIN_BASE = 11'h7F8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data
);

    tod_time_t run_time, hold_val, shadow_val;
    logic      load_pulse, ctrl_read;

    tod_bus_regs #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .run       (run_time),
        .rd_data   (rd_data),
        .load      (load_pulse),
        .hold      (hold_val),
        .shadow    (shadow_val),
        .ctrl_read (ctrl_read)
    );

    tod_count_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .load     (load_pulse),
        .load_val (hold_val),
        .run      (run_time)
    );

endmodule

// File: rtl/tod_clock_checker.sv
// Assertion checker for tod_clock_regs, attached by bind.
module tod_clock_checker
    import tod_pkg::*;
#(
    parameter int                ADDR_W   = 11,
    parameter logic [ADDR_W-1:0] WIN_BASE = 11'h7F8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rd_data,
    input logic              load,
    input tod_time_t         hold,
    input tod_time_t         run,
    input tod_time_t         shadow,
    input logic              ctrl_read
);

    // R2: addresses outside the window read zero.
    assert_outside_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-1:3] != WIN_BASE[ADDR_W-1:3]) |-> (rd_data == 8'h00));

    // R3: a load places the holding copy into the counters.
    assert_load_takes_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (run == $past(hold)));

    // R9: with stop set and no load, the counters do not move.
    assert_stop_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run.stop && !load) |=> $stable(run));

    // R5: a tick advances the seconds units digit when it is below nine.
    assert_sec_units_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !run.stop && !load && (run.sec[3:0] != 4'd9))
        |=> (run.sec[3:0] == $past(run.sec[3:0]) + 4'd1));

    // R4: without tick or load the counters hold.
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(run));

    // R12: the stored flags change only by a load.
    assert_flags_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({run.kick, run.ftest, run.stop}));

    // R10: while frozen the readable copy does not change.
    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_read |=> $stable(shadow));

endmodule

bind tod_clock_regs tod_clock_checker #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_1hz),
    .addr      (addr),
    .rd_data   (rd_data),
    .load      (load_pulse),
    .hold      (hold_val),
    .run       (run_time),
    .shadow    (shadow_val),
    .ctrl_read (ctrl_read)
);

// File: tb/tod_clock_regs_test.sv
module tod_clock_regs_test;

    localparam logic [10:0] A_CTRL = 11'h7F8, A_SEC = 11'h7F9, A_MIN = 11'h7FA,
                            A_HR = 11'h7FB, A_DOW = 11'h7FC, A_DATE = 11'h7FD,
                            A_MON = 11'h7FE, A_YR = 11'h7FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic [10:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [10:0] a;
        logic [7:0]  exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    event      sb_ev;

    tod_clock_regs uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    always #5 clk = ~clk;

    // Monitor: pop expected items and compare against the read port.
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rd_data, it.exp);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [10:0] a, input logic [7:0] d, input logic t);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; tick_1hz = t;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    // Driver: set the read address and push the expected byte.
    task automatic expect_rd(input logic [10:0] a, input logic [7:0] e, input string tag);
        exp_item_t it;
        addr = a;
        #1;
        it.a = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        ->sb_ev;
        #1;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y);
        bus_write(A_CTRL, 8'h80, 1'b0);
        bus_write(A_SEC, s, 1'b0);
        bus_write(A_MIN, m, 1'b0);
        bus_write(A_HR, h, 1'b0);
        bus_write(A_DOW, dw, 1'b0);
        bus_write(A_DATE, dt, 1'b0);
        bus_write(A_MON, mo, 1'b0);
        bus_write(A_YR, y, 1'b0);
        bus_write(A_CTRL, 8'h00, 1'b0);
        idle(2);
    endtask

    task automatic expect_all(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                              input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                              input logic [7:0] y, input string tag);
        expect_rd(A_SEC, s, tag);
        expect_rd(A_MIN, m, tag);
        expect_rd(A_HR, h, tag);
        expect_rd(A_DOW, dw, tag);
        expect_rd(A_DATE, dt, tag);
        expect_rd(A_MON, mo, tag);
        expect_rd(A_YR, y, tag);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        expect_rd(A_CTRL, 8'h00, "R1 ctrl");
        expect_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 reset");

        // R3 R12 load with flags; R2 field placement
        set_time(8'h58, 8'h59, 8'hA3, 8'h47, 8'h28, 8'h02, 8'h23);
        expect_all(8'h58, 8'h59, 8'hA3, 8'h47, 8'h28, 8'h02, 8'h23, "R3 R2 loaded");
        tick_once(); idle(1);
        expect_rd(A_SEC, 8'h59, "R5 sec step");
        // R5 R6 R7 R12: 23:59:59 on Feb 28 of non-leap year 23
        tick_once(); idle(1);
        expect_all(8'h00, 8'h00, 8'h80, 8'h41, 8'h01, 8'h03, 8'h23, "R5 R6 R7 R12 cascade");

        // R7 leap February
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        tick_once(); idle(1);
        expect_rd(A_DATE, 8'h29, "R7 leap date");
        expect_rd(A_MON, 8'h02, "R7 leap month");
        expect_rd(A_DOW, 8'h03, "R6 dow step");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        tick_once(); idle(1);
        expect_rd(A_DATE, 8'h01, "R7 leap wrap date");
        expect_rd(A_MON, 8'h03, "R7 leap wrap month");

        // R7 thirty-day month
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h24);
        tick_once(); idle(1);
        expect_rd(A_DATE, 8'h01, "R7 30-day date");
        expect_rd(A_MON, 8'h05, "R7 30-day month");

        // R8 R6 year rollover
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        tick_once(); idle(1);
        expect_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R8 R6 year wrap");

        // R9 stop flag
        set_time(8'h90, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        tick_once(); tick_once(); tick_once(); idle(1);
        expect_rd(A_SEC, 8'h90, "R9 stopped");
        set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        tick_once(); idle(1);
        expect_rd(A_SEC, 8'h11, "R9 running");

        // R10 freeze
        bus_write(A_CTRL, 8'h40, 1'b0);
        tick_once(); tick_once(); idle(1);
        expect_rd(A_SEC, 8'h11, "R10 frozen");
        expect_rd(A_CTRL, 8'h40, "R10 ctrl");
        bus_write(A_CTRL, 8'h00, 1'b0);
        expect_rd(A_SEC, 8'h11, "R10 not yet refreshed");
        idle(1);
        expect_rd(A_SEC, 8'h13, "R10 refreshed");

        // R11 trim bit and zero bits
        bus_write(A_CTRL, 8'h3F, 1'b0);
        expect_rd(A_CTRL, 8'h20, "R11 ctrl");
        bus_write(A_CTRL, 8'h00, 1'b0);
        expect_rd(A_CTRL, 8'h00, "R11 cleared");

        // R4 ignored field write
        bus_write(A_SEC, 8'h33, 1'b0);
        idle(2);
        expect_rd(A_SEC, 8'h13, "R4 ignored");

        // R2 outside window
        bus_write(11'h7F0, 8'hC0, 1'b0);
        idle(1);
        expect_rd(A_CTRL, 8'h00, "R2 outside write");
        expect_rd(11'h7F0, 8'h00, "R2 outside read");
        expect_rd(11'h000, 8'h00, "R2 low read");

        // R3 snapshot at load-enable rise; tick during edit is overwritten
        bus_write(A_CTRL, 8'h80, 1'b0);
        tick_once();
        bus_write(A_MIN, 8'h15, 1'b0);
        bus_write(A_CTRL, 8'h00, 1'b0);
        idle(2);
        expect_rd(A_SEC, 8'h13, "R3 snapshot sec");
        expect_rd(A_MIN, 8'h15, "R3 edited min");

        // R13 load and tick in same cycle
        bus_write(A_CTRL, 8'h80, 1'b0);
        bus_write(A_SEC, 8'h30, 1'b0);
        bus_write(A_CTRL, 8'h00, 1'b1);
        idle(2);
        expect_rd(A_SEC, 8'h30, "R13 load wins");
        tick_once(); idle(1);
        expect_rd(A_SEC, 8'h31, "R13 after");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule